// File: doc/BRIEF.md
# Incremental Vector Byte Decoder

This block decodes the byte stream of a vector display while it runs in incremental mode. Each data word holds two bytes, and the high byte is presented first. Each byte is one of two kinds. An increment byte makes a short, scaled, relative move of the beam, and it can also ask for a line to be drawn. An escape byte is a control code. It can leave incremental mode, ask for a subroutine return, or apply coarse steps and truncation to the X and Y positions.

The surrounding engine keeps the 11-bit X and Y accumulators. It presents their current values with each byte and writes back the results this block returns. The block tracks whether incremental mode is active. An entry pulse switches the mode on, and the byte offered in that same cycle is decoded at once. Bytes offered while the mode is off are dropped. So when a high byte leaves the mode, the low byte of that word has no effect. A line request holds its start and end points until the drawing side acknowledges it.

Top module: `inc_byte_decoder`

## Requirements
- R1: After reset, `inc_active`, `res_vld`, `mode_exit`, `ret_req` and `line_req` are all 0.
- R2: A byte offered with `enter` high is decoded in that cycle, and `inc_active` is 1 afterwards unless that byte leaves the mode.
- R3: A byte offered while `inc_active` is 0 and `enter` is 0 is dropped: `res_vld` stays 0 in the following cycle and the mode stays off. This covers the low byte after a high byte that left the mode.
- R4: A byte with bit 7 set is an increment byte. Its X result is `x_in` plus or minus `scale` times the magnitude in bits 4:3, and bit 5 set means minus. The result is taken modulo 2048.
- R5: In an increment byte, the Y result is `y_in` plus or minus `scale` times the magnitude in bits 1:0, and bit 2 set means minus. The result is taken modulo 2048.
- R6: An increment byte with bit 6 set raises `line_req`, with the start point (`x_in`, `y_in`) and the end point (the new X and Y). The request and its coordinates hold until `line_ack`. With bit 6 clear, no line is requested.
- R7: A byte with bit 7 clear is an escape byte. If its bit 6 is set, the block pulses `mode_exit` and clears `inc_active`.
- R8: An escape byte with bit 5 set pulses `ret_req`. Otherwise `ret_req` stays 0.
- R9: In an escape byte, bit 4 adds 32 to X modulo 2048. After that, bit 3 ANDs X with octal 3740.
- R10: In an escape byte, bit 1 adds 32 to Y modulo 2048. After that, bit 0 ANDs Y with octal 3740.
- R11: All results (`res_vld`, `x_out`, `y_out`, `mode_exit`, `ret_req`, line fields) appear on the clock edge that follows the accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enter | input | 1 | Switch incremental mode on; decode the byte offered in this cycle |
| byte_vld | input | 1 | A byte is offered on `byte_in` |
| byte_in | input | 8 | Increment or escape byte |
| scale | input | 3 | Multiplier for increment step magnitudes |
| x_in | input | 11 | Current X accumulator |
| y_in | input | 11 | Current Y accumulator |
| line_ack | input | 1 | Drawing side has taken the pending line |
| res_vld | output | 1 | `x_out`/`y_out` hold the result of a decoded byte |
| x_out | output | 11 | Updated X accumulator |
| y_out | output | 11 | Updated Y accumulator |
| inc_active | output | 1 | Incremental mode is on |
| mode_exit | output | 1 | Pulse: the decoded byte left incremental mode |
| ret_req | output | 1 | Pulse: the decoded byte requests a subroutine return |
| line_req | output | 1 | A line is pending |
| line_x0 | output | 11 | Line start X |
| line_y0 | output | 11 | Line start Y |
| line_x1 | output | 11 | Line end X |
| line_y1 | output | 11 | Line end Y |

## Verification
Every result of a decoded byte is due exactly one clock edge after the byte is offered. The bench drives each byte on a falling edge and reads all outputs at the next falling edge, which lies half a period after the one rising edge that registers them. A pending line is read again one full cycle later with no acknowledge, to confirm that it holds. After the acknowledge it is read once more, one cycle on, to confirm it has cleared. When a byte leaves the mode, a follow-up byte without `enter` is offered, and the bench checks one cycle later that nothing was produced.

// File: rtl/inc_byte_decoder.sv
module inc_byte_decoder #(
  parameter int AW = 11,
  parameter int SW = 3,
  parameter int STEP = 32,
  parameter logic [AW-1:0] TRUNC = 11'o3740
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enter,
  input  logic          byte_vld,
  input  logic [7:0]    byte_in,
  input  logic [SW-1:0] scale,
  input  logic [AW-1:0] x_in,
  input  logic [AW-1:0] y_in,
  input  logic          line_ack,
  output logic          res_vld,
  output logic [AW-1:0] x_out,
  output logic [AW-1:0] y_out,
  output logic          inc_active,
  output logic          mode_exit,
  output logic          ret_req,
  output logic          line_req,
  output logic [AW-1:0] line_x0,
  output logic [AW-1:0] line_y0,
  output logic [AW-1:0] line_x1,
  output logic [AW-1:0] line_y1
);

  logic          take, is_inc, draw, leave, ret;
  logic [AW-1:0] dx, dy, x_inc, y_inc, x_stp, y_stp, x_esc, y_esc, x_nxt, y_nxt;

  assign take   = byte_vld && (inc_active || enter);
  assign is_inc = byte_in[7];
  assign draw   = take &&  is_inc && byte_in[6];
  assign leave  = take && !is_inc && byte_in[6];
  assign ret    = take && !is_inc && byte_in[5];

  assign dx    = AW'(scale) * AW'(byte_in[4:3]);
  assign dy    = AW'(scale) * AW'(byte_in[1:0]);
  assign x_inc = byte_in[5] ? x_in - dx : x_in + dx;
  assign y_inc = byte_in[2] ? y_in - dy : y_in + dy;

  assign x_stp = byte_in[4] ? x_in + AW'(STEP) : x_in;
  assign y_stp = byte_in[1] ? y_in + AW'(STEP) : y_in;
  assign x_esc = byte_in[3] ? (x_stp & TRUNC) : x_stp;
  assign y_esc = byte_in[0] ? (y_stp & TRUNC) : y_stp;

  assign x_nxt = is_inc ? x_inc : x_esc;
  assign y_nxt = is_inc ? y_inc : y_esc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_active <= 1'b0;
      res_vld    <= 1'b0;
      mode_exit  <= 1'b0;
      ret_req    <= 1'b0;
      x_out      <= '0;
      y_out      <= '0;
    end else begin
      res_vld   <= take;
      mode_exit <= leave;
      ret_req   <= ret;
      if (take) begin
        x_out <= x_nxt;
        y_out <= y_nxt;
      end
      if (leave)      inc_active <= 1'b0;
      else if (enter) inc_active <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_req <= 1'b0;
      line_x0  <= '0;
      line_y0  <= '0;
      line_x1  <= '0;
      line_y1  <= '0;
    end else if (draw) begin
      line_req <= 1'b1;
      line_x0  <= x_in;
      line_y0  <= y_in;
      line_x1  <= x_nxt;
      line_y1  <= y_nxt;
    end else if (line_ack) begin
      line_req <= 1'b0;
    end
  end

  // R3
  drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld && !inc_active && !enter |=> !res_vld);

  // R6
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_req && !line_ack && !draw |=> line_req && $stable(line_x0) && $stable(line_y0)
                                       && $stable(line_x1) && $stable(line_y1));

  // R7
  exit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_exit |-> !inc_active && res_vld);

  // R8
  ret_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_req |-> res_vld);

  // R11
  res_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> $past(byte_vld));

  // R2
  enter_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter && !leave |=> inc_active);

endmodule

// File: tb/tb_inc_byte_decoder.sv
module tb_inc_byte_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enter = 1'b0, byte_vld = 1'b0, line_ack = 1'b0;
  logic [7:0]  byte_in = '0;
  logic [2:0]  scale = '0;
  logic [10:0] x_in = '0, y_in = '0;
  logic        res_vld, inc_active, mode_exit, ret_req, line_req;
  logic [10:0] x_out, y_out, line_x0, line_y0, line_x1, line_y1;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  inc_byte_decoder dut (
    .clk(clk), .rst_n(rst_n), .enter(enter), .byte_vld(byte_vld), .byte_in(byte_in),
    .scale(scale), .x_in(x_in), .y_in(y_in), .line_ack(line_ack),
    .res_vld(res_vld), .x_out(x_out), .y_out(y_out), .inc_active(inc_active),
    .mode_exit(mode_exit), .ret_req(ret_req), .line_req(line_req),
    .line_x0(line_x0), .line_y0(line_y0), .line_x1(line_x1), .line_y1(line_y1)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (byte %0h scale %0d x %0d y %0d)",
               tag, act, exp, byte_in, scale, x_in, y_in);
    end
  endtask

  function automatic int exp_x(input int b, input int s, input int x);
    int t;
    if (b[7]) begin
      t = s * ((b >> 3) & 3);
      return b[5] ? ((x - t) & 2047) : ((x + t) & 2047);
    end
    t = x;
    if (b[4]) t = (t + 32) & 2047;
    if (b[3]) t = t & 'h7E0;
    return t;
  endfunction

  function automatic int exp_y(input int b, input int s, input int y);
    int t;
    if (b[7]) begin
      t = s * (b & 3);
      return b[2] ? ((y - t) & 2047) : ((y + t) & 2047);
    end
    t = y;
    if (b[1]) t = (t + 32) & 2047;
    if (b[0]) t = t & 'h7E0;
    return t;
  endfunction

  initial begin
    #1600000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int pos_x[3];
    int pos_y[3];
    int ex, ey;
    bit drw, ext;
    pos_x = '{2047, 19, 933};
    pos_y = '{5, 2040, 1061};
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1 inc_active", inc_active, 0);
    chk("R1 res_vld", res_vld, 0);
    chk("R1 line_req", line_req, 0);
    chk("R1 mode_exit", mode_exit, 0);
    chk("R1 ret_req", ret_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3: byte without enter while mode off is dropped
    byte_vld = 1'b1; byte_in = 8'hC9;
    @(negedge clk);
    byte_vld = 1'b0;
    chk("R3 idle drop", res_vld, 0);
    chk("R3 mode off", inc_active, 0);

    for (int p = 0; p < 3; p++) begin
      for (int s = 0; s < 8; s++) begin
        for (int b = 0; b < 256; b++) begin
          enter = 1'b1; byte_vld = 1'b1; byte_in = 8'(b);
          scale = 3'(s); x_in = 11'(pos_x[p]); y_in = 11'(pos_y[p]);
          ex = exp_x(b, s, pos_x[p]);
          ey = exp_y(b, s, pos_y[p]);
          drw = b[7] && b[6];
          ext = !b[7] && b[6];
          @(negedge clk);
          enter = 1'b0; byte_vld = 1'b0;
          // R11: results due one edge later
          chk("R11 res_vld", res_vld, 1);
          if (b[7]) begin
            chk("R4 x", x_out, ex);
            chk("R5 y", y_out, ey);
          end else begin
            chk("R9 x", x_out, ex);
            chk("R10 y", y_out, ey);
          end
          chk("R7 exit", mode_exit, ext);
          chk("R2 active", inc_active, !ext);
          chk("R8 ret", ret_req, !b[7] && b[5]);
          chk("R6 line_req", line_req, drw);
          if (drw) begin
            chk("R6 x0", line_x0, pos_x[p]);
            chk("R6 y0", line_y0, pos_y[p]);
            chk("R6 x1", line_x1, ex);
            chk("R6 y1", line_y1, ey);
            @(negedge clk);
            chk("R6 hold", line_req, 1);
            chk("R6 hold x1", line_x1, ex);
            chk("R11 pulse ends", res_vld, 0);
            line_ack = 1'b1;
            @(negedge clk);
            line_ack = 1'b0;
            chk("R6 cleared", line_req, 0);
          end
          if (ext) begin
            byte_vld = 1'b1; byte_in = 8'h9B;
            @(negedge clk);
            byte_vld = 1'b0;
            chk("R3 skip after exit", res_vld, 0);
            chk("R3 still off", inc_active, 0);
          end
        end
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule